// File: doc/BRIEF.md
# Programmable Square Wave Divider

The block turns a 32768 Hz slow clock into a square wave whose rate is chosen by a 4-bit code. It runs a free-running binary counter on the slow clock. The output is one counter bit, picked by the code, so the wave has a 50% duty cycle.

The code does not map monotonically onto the output rate:

- Code 3 gives the fastest rate.
- Codes 3 to 15 each halve the rate of the code before.
- Codes 1 and 2 give the same rates as codes 8 and 9.
- Code 0 holds the output low.

A function-select enable gates the whole output. The code may change at any time. The counter never restarts, so a new rate keeps the counter's phase.

A two-state controller decides whether the pin carries the wave:

- State `ST_QUIET` drives the output low.
- State `ST_WAVE` passes the selected counter bit to the output.
- Transition *start* (`ST_QUIET` to `ST_WAVE`) happens on an edge that samples the enable high and a nonzero code.
- Transition *stop* (`ST_WAVE` to `ST_QUIET`) happens on an edge that samples the enable low or code 0.
- In every other case the state holds.

Top module: `sqw_gen`

## Requirements
- R1: While reset is asserted and after its release, the output is low and the counter starts from zero.
- R2: When the sampled code is 0, the output is low even with the enable high.
- R3: When the sampled enable is low, the output is low for every code.
- R4: For codes 3 to 15 the output after n slow-clock edges since reset equals bit (code-2) of n. This gives 8192 Hz for code 3 down to 2 Hz for code 15.
- R5: Code 1 produces the same output as code 8, which is bit 6 (256 Hz). Code 2 produces the same output as code 9, which is bit 7 (128 Hz).
- R6: Over any whole number of periods, the output is high for exactly half the cycles.
- R7: A change of code takes effect on the next edge and does not restart the counter. The output follows the new bit of the continuing count.
- R8: Inputs act with one edge of latency. The output after an edge reflects the enable and code sampled at that edge.
- R9: The counter is 15 bits wide and wraps from 32767 to 0 without disturbing the selected output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32768 Hz slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_en_i | input | 1 | High when the pin function selects square-wave output |
| rate_code_i | input | 4 | Frequency code (0 = low, 1..15 per R4/R5) |
| wave_o | output | 1 | Square wave output |

## Verification
The bench builds the block with its default parameters: a 15-bit counter and a 4-bit code. With these values all sixteen codes are legal taps. The run is long enough to watch the counter wrap past 32767 and to see whole periods of every rate up to 256 cycles. For the slow codes it sees partial periods of the 16384-cycle wave. The bench compares every cycle against a count kept from its own edge counter, so random code changes test that the phase is kept across a change of code.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_WAVE  = 1'b1
    } sqw_state_e;

    // Counter bit index that carries the rate chosen by a code.
    // Codes 1 and 2 reuse the taps of codes 8 and 9.
    function automatic int unsigned tap_of(input int unsigned code);
        if (code == 1) return 6;
        if (code == 2) return 7;
        if (code >= 3) return code - 2;
        return 0;
    endfunction

endpackage

// File: rtl/sqw_counter.sv
module sqw_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Each stage toggles when every stage below it is high (ripple-style carry).
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        if (k == 0) begin : g_lsb
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) cnt_q[k] <= 1'b0;
                else         cnt_q[k] <= ~cnt_q[k];
            end
        end else begin : g_upper
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)           cnt_q[k] <= 1'b0;
                else if (&cnt_q[k-1:0]) cnt_q[k] <= ~cnt_q[k];
            end
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sqw_tap_sel.sv
module sqw_tap_sel #(
    parameter int CNT_W  = 15,
    parameter int CODE_W = 4
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              bit_o
);

    localparam int IDX_W = $clog2(CNT_W);

    int unsigned      tap;
    logic [IDX_W-1:0] idx;

    always_comb begin
        tap   = sqw_pkg::tap_of(32'(code_i));
        idx   = tap[IDX_W-1:0];
        bit_o = 1'b0;
        if (tap < CNT_W) bit_o = cnt_i[idx];
    end

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen #(
    parameter int CNT_W  = 15,
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              func_en_i,
    input  logic [CODE_W-1:0] rate_code_i,
    output logic              wave_o
);

    import sqw_pkg::*;

    sqw_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              tap_bit;
    logic              want_wave;

    sqw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt_q)
    );

    sqw_tap_sel #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_tap (
        .cnt_i  (cnt_q),
        .code_i (code_q),
        .bit_o  (tap_bit)
    );

    assign want_wave = func_en_i && (rate_code_i != '0);

    // Next-state logic: start / stop / hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (want_wave)  state_d = ST_WAVE;
            ST_WAVE:  if (!want_wave) state_d = ST_QUIET;
            default:                  state_d = ST_QUIET;
        endcase
    end

    // State register and sampled code.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_QUIET;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= rate_code_i;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_QUIET: wave_o = 1'b0;
            ST_WAVE:  wave_o = tap_bit;
            default:  wave_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
    parameter int CNT_W  = 15,
    parameter int CODE_W = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                func_en_i,
    input logic [CODE_W-1:0]   rate_code_i,
    input logic                wave_o,
    input logic [CNT_W-1:0]    cnt_q,
    input sqw_pkg::sqw_state_e state_q
);

    logic [1:0] age_q;
    logic       fast_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign fast_run = func_en_i && (rate_code_i == CODE_W'(3));

    // R2 R3
    off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1 && $past(!func_en_i || rate_code_i == '0)) |-> !wave_o);

    // R1
    first_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd1) |-> !wave_o);

    // R9
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R8
    start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd1 && $past(func_en_i && rate_code_i != '0)) |-> (state_q == sqw_pkg::ST_WAVE));

    // R4
    fast_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(fast_run, 1) && $past(fast_run, 2) && $past(fast_run, 3))
        |-> (wave_o != $past(wave_o, 2)));

endmodule

bind sqw_gen sqw_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .func_en_i   (func_en_i),
    .rate_code_i (rate_code_i),
    .wave_o      (wave_o),
    .cnt_q       (cnt_q),
    .state_q     (state_q)
);

// File: tb/sqw_gen_tb.sv
module sqw_gen_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] code = 4'd0;
    logic       wave;

    int nchk = 0;
    int nfail = 0;
    int unsigned n = 0;
    logic [3:0] prev_code = 4'd0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sqw_gen u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .func_en_i   (en),
        .rate_code_i (code),
        .wave_o      (wave)
    );

    function automatic int unsigned ref_tap(input logic [3:0] c);
        if (c == 4'd1) return 6;
        if (c == 4'd2) return 7;
        return 32'(c) - 2;
    endfunction

    function automatic logic ref_wave(input logic e, input logic [3:0] c, input int unsigned cnt);
        if (!e || c == 4'd0) return 1'b0;
        return logic'(((cnt % 32768) >> ref_tap(c)) & 1);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at count %0d: actual %0b expected %0b", req, n, act, exp);
        end
    endtask

    // Apply inputs, take one edge, check at the following falling edge.
    task automatic step(input logic e, input logic [3:0] c, input string tag, output logic got);
        string req;
        en = e;
        code = c;
        @(posedge clk);
        n++;
        @(negedge clk);
        got = wave;
        if (tag != "")                       req = tag;
        else if (!e)                         req = "R3";
        else if (c == 4'd0)                  req = "R2";
        else if (n >= 32768)                 req = "R9";
        else if (c != prev_code)             req = "R7";
        else if (c == 4'd1 || c == 4'd2)     req = "R5";
        else                                 req = "R4";
        check(req, wave, ref_wave(e, c, n));
        prev_code = c;
    endtask

    initial begin
        logic g;
        int hi;
        void'($urandom(32'd7));
        en = 1'b1;
        code = 4'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", wave, 1'b0);
        rst_n = 1'b1;
        n = 0;

        for (int i = 0; i < 8; i++) step(1'b1, 4'd0, "R2", g);
        for (int c = 1; c < 16; c++) step(1'b0, 4'(c), "R3", g);

        // R8: enable from quiet exactly when the expected bit is high.
        while ((((n + 1) >> 1) & 1) == 0) step(1'b0, 4'd3, "", g);
        step(1'b1, 4'd3, "R8", g);

        // R5: alias codes against their twins, phase-continuous.
        for (int i = 0; i < 300; i++) step(1'b1, 4'd1, "R5", g);
        for (int i = 0; i < 300; i++) step(1'b1, 4'd2, "R5", g);

        // R6: duty cycle over whole periods.
        hi = 0;
        for (int i = 0; i < 64; i++) begin step(1'b1, 4'd3, "", g); hi += int'(g); end
        check("R6", logic'(hi == 32), 1'b1);
        hi = 0;
        for (int i = 0; i < 256; i++) begin step(1'b1, 4'd7, "", g); hi += int'(g); end
        check("R6", logic'(hi == 128), 1'b1);

        // R7: rapid code changes mid-run.
        for (int i = 0; i < 64; i++) step(1'b1, 4'(3 + (i % 5)), "R7", g);

        // Random mix; runs past the counter wrap (R9).
        for (int i = 0; i < 40000; i++) begin
            logic e;
            logic [3:0] c;
            c = code;
            if (($urandom % 16) == 0) c = 4'($urandom % 16);
            e = (($urandom % 8) != 0);
            step(e, c, "", g);
        end
        for (int i = 0; i < 200; i++) step(1'b1, 4'd3, "R9", g);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule